// File: doc/BRIEF.md
# Overlapped Ping-Pong Window Buffer

This block collects a stream of samples, one per clock, and presents a downstream processor with a window of `N` samples. A new window is ready every `N/4` accepted samples. Each window shares three quarters of its samples with the window before it, so the overlap is 75%.

The block holds two banks. Each bank is split into four quarter memories of `N/4` words each. One bank is the *view* bank, which the consumer reads. The other is the *fill* bank. For each accepted sample, the fill bank is written at one address in all four lanes at once:

- Lane 3 takes the new sample.
- Lanes 0 to 2 take the same address from lanes 1 to 3 of the view bank.

When a quarter is complete, the banks swap roles and a one-cycle ready pulse is issued. The consumer gives one address and gets four samples in the same cycle, one from each lane.

Top module: `overlap_pingpong_buf`

## Requirements
- R1: A sample on `in_data` is accepted on a rising clock edge only when `in_valid` is high. A sample offered with `in_valid` low changes neither the window contents nor the timing of the ready pulse.
- R2: `win_ready` goes high for exactly one cycle, in the cycle after the clock edge that accepts the (k·N/4)-th sample since reset, for every k ≥ 4. It is low in all other cycles.
- R3: Until N samples have been accepted since reset, `win_ready` stays low and `rd_data` reads as all zeros.
- R4: Once primed, the visible window holds the N most recently accepted samples up to the last quarter boundary, oldest first. Window position p = q·(N/4) + `rd_addr` appears on lane q, which is `rd_data[q*W +: W]`. A new window is visible in the same cycle that `win_ready` is high.
- R5: Consecutive windows overlap by 75%. Lanes 0 to 2 of a new window equal lanes 1 to 3 of the previous window, and lane 3 holds the newest N/4 samples.
- R6: Between ready pulses, the visible window does not change while further samples are being accepted.
- R7: While reset (`rst_n` low, asynchronous, active low) is asserted, `win_ready` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | W | Input sample |
| rd_addr | input | log2(N/4) | Word address within each quarter for the consumer read |
| rd_data | output | 4·W | Four window samples, lane q at bits [q*W +: W] |
| win_ready | output | 1 | One-cycle pulse when a new window becomes visible |

## Verification
An unbroken burst of valid samples after reset shows exactly where priming ends. It also shows that the first window is the first N samples in order.

A long random stretch with roughly one idle slot in four does three things:
- it separates correct gating of `in_valid` from counting every cycle;
- it shows the quarter shift between windows;
- with a changing read address, it checks every lane at every address against a history model.

A long idle spell with garbage on `in_data` shows that unqualified data never reaches a window. A second reset partway through shows that priming starts again from scratch.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  localparam int unsigned LANES = 4;

  // saturating quarter counter used for priming
  function automatic logic [2:0] quarters_next(input logic [2:0] c);
    return (c == 3'd4) ? 3'd4 : c + 3'd1;
  endfunction

  // lane that takes the newest input; others copy from lane+1 of the view bank
  function automatic bit lane_is_fresh(input int unsigned q);
    return q == LANES - 1;
  endfunction

  // a full window is present once four quarters have been collected
  function automatic bit is_primed(input logic [2:0] c);
    return c == 3'd4;
  endfunction
endpackage

// File: rtl/obuf_quarter_ram.sv
module obuf_quarter_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/obuf_fill_ctrl.sv
module obuf_fill_ctrl
  import obuf_pkg::*;
#(
  parameter int N  = 64,
  localparam int Q  = N / 4,
  localparam int AW = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [AW-1:0] wr_addr,
  output logic          fill_sel,
  output logic          primed,
  output logic          win_ready,
  output logic          quarter_done
);
  logic [2:0] quarters;
  logic       last_slot;

  assign last_slot    = (wr_addr == AW'(Q - 1));
  assign quarter_done = in_valid && last_slot;
  assign primed       = is_primed(quarters);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr   <= '0;
      fill_sel  <= 1'b0;
      quarters  <= '0;
      win_ready <= 1'b0;
    end else begin
      win_ready <= 1'b0;
      if (in_valid) begin
        if (last_slot) begin
          wr_addr   <= '0;
          fill_sel  <= ~fill_sel;
          quarters  <= quarters_next(quarters);
          win_ready <= (quarters >= 3'd3);
        end else begin
          wr_addr <= wr_addr + 1'b1;
        end
      end
    end
  end

  // R2: a pulse only follows an accepted sample
  p_ready_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> $past(in_valid));
  // R2: pulse lasts one cycle
  p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);
  // R3: no pulse before four quarters are held
  p_ready_needs_prime_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> primed);
  // R1: idle cycles leave fill position and bank choice alone
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(wr_addr) && $stable(fill_sel)));
  // R5: banks exchange roles at every quarter boundary
  p_swap_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_done |=> (fill_sel != $past(fill_sel)));
endmodule

// File: rtl/overlap_pingpong_buf.sv
module overlap_pingpong_buf
  import obuf_pkg::*;
#(
  parameter int N  = 64,
  parameter int W  = 16,
  localparam int Q  = N / 4,
  localparam int AW = $clog2(Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [4*W-1:0]    rd_data,
  output logic              win_ready
);
  logic [AW-1:0] wr_addr;
  logic          fill_sel;
  logic          primed;
  logic          quarter_done;
  logic [1:0]    bank_we;

  logic [W-1:0] copy_rd [2][LANES];
  logic [W-1:0] view_rd [2][LANES];

  obuf_fill_ctrl #(.N(N)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .wr_addr      (wr_addr),
    .fill_sel     (fill_sel),
    .primed       (primed),
    .win_ready    (win_ready),
    .quarter_done (quarter_done)
  );

  assign bank_we[0] = in_valid && (fill_sel == 1'b0);
  assign bank_we[1] = in_valid && (fill_sel == 1'b1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar q = 0; q < LANES; q++) begin : g_lane
      logic [W-1:0] wdata;
      if (lane_is_fresh(q)) begin : g_fresh
        assign wdata = in_data;
      end else begin : g_shift
        assign wdata = copy_rd[1-b][q+1];
      end
      obuf_quarter_ram #(.W(W), .DEPTH(Q)) u_ram (
        .clk     (clk),
        .we      (bank_we[b]),
        .waddr   (wr_addr),
        .wdata   (wdata),
        .raddr_a (wr_addr),
        .rdata_a (copy_rd[b][q]),
        .raddr_b (rd_addr),
        .rdata_b (view_rd[b][q])
      );
    end
  end

  always_comb begin
    rd_data = '0;
    for (int q = 0; q < LANES; q++) begin
      if (primed) rd_data[q*W +: W] = view_rd[~fill_sel][q];
    end
  end

  // R5: only the fill bank is ever written, never both banks at once
  p_bank_we_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  // R1: writes only occur for accepted samples
  p_write_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != 2'b00) |-> in_valid);
endmodule

// File: tb/overlap_pingpong_buf_tb_top.sv
module overlap_pingpong_buf_tb_top;
  localparam int N  = 64;
  localparam int W  = 16;
  localparam int Q  = N / 4;
  localparam int AW = $clog2(Q);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [4*W-1:0] rd_data;
  logic           win_ready;

  int compared = 0;
  int mismatched = 0;
  int cnt = 0;
  logic [W-1:0] hist [0:8191];

  always #5 clk = ~clk;

  overlap_pingpong_buf #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .win_ready(win_ready)
  );

  function automatic logic [4*W-1:0] expected_view(input int total, input int addr);
    logic [4*W-1:0] v;
    int wend;
    v = '0;
    if (total >= N) begin
      wend = (total / Q) * Q;
      for (int q = 0; q < 4; q++) v[q*W +: W] = hist[wend - N + q*Q + addr];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 ready", {63'd0, win_ready}, '0);
    check("R7 data", rd_data, '0);
    cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic [AW-1:0] a);
    logic exp_rdy;
    string tag;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    rd_addr  = a;
    @(posedge clk);
    if (v) begin
      hist[cnt] = d;
      cnt++;
    end
    #1;
    exp_rdy = v && (cnt % Q == 0) && (cnt >= N);
    check((cnt < N) ? "R3 ready" : "R2 ready", {63'd0, win_ready}, {63'd0, exp_rdy});
    if (cnt < N) tag = "R3 data";
    else if (exp_rdy) tag = ((cnt / Q) * Q == N) ? "R4 data" : "R5 data";
    else if (!v) tag = "R1 data";
    else tag = "R6 data";
    check(tag, rd_data, expected_view(cnt, int'(a)));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // directed: unbroken burst primes exactly at N
    for (int i = 0; i < N + 2*Q; i++) step(1'b1, W'(16'h1000 + i), AW'(i));
    // directed: reset partway, priming restarts
    do_reset();
    for (int i = 0; i < N - 1; i++) step(1'b1, W'($urandom), AW'($urandom));
    // random mix
    for (int i = 0; i < 2500; i++)
      step(($urandom % 4) != 0, W'($urandom), AW'($urandom));
    // directed: long idle with garbage data
    for (int i = 0; i < 60; i++) step(1'b0, W'($urandom), AW'(i));
    // continuous burst sweeping addresses
    for (int i = 0; i < 8*Q; i++) step(1'b1, W'($urandom), AW'(i));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule